// File: doc/BRIEF.md
# Windowed Independent Watchdog Timer

This block is a watchdog that runs from its own clock and takes its whole setup from a 13-bit configuration word. It captures that word once, on the first clock edge after reset. A prescaler slows the clock down, and its output steps a down-counter whose length is selectable. Software keeps the watchdog alive by writing a two-byte refresh sequence. The sequence only counts when it lands inside a window, and the window is placed as fractions of the counter period. If the counter runs out, or a refresh arrives outside the window, the block raises one action. That action is either a reset request or a single-cycle non-maskable interrupt request.

A configuration bit chooses whether counting begins by itself after reset or waits for the first refresh. A second bit lets a sleep indication freeze the count. A boot-mode input replaces the stored word with all ones, which is the erased state. Two sticky flags record underflow and refresh error. The refresh port and the flag-clear port are plain write strobes with no back-pressure: the block takes every write in the cycle its strobe is high.

Top module: `wdog_windowed`

## Requirements
- R1: On the first edge after reset the block latches the configuration word, or all ones when boot_mode is high. The word's fields are: bit 0 stop-after-reset (1 = stopped); bits 2:1 period code; bits 6:3 divider code; bits 8:7 window-end code; bits 10:9 window-start code; bit 11 action (1 = reset request, 0 = NMI); bit 12 sleep hold (1 = pause). While in reset, every status and action output is low.
- R2: Period codes 0, 1, 2 and 3 select 128, 512, 1024 and 2048 counts. Divider codes 0 to 5 select 1, 16, 32, 64, 128 and 256, and any other divider code selects 1. Measured from the edge that loads the counter, underflow takes exactly period × divider clock cycles.
- R3: A refresh is a write of 00h followed, on the very next write, by FFh. The FFh write is the one that is evaluated. A write order such as 00h, 55h, FFh, or a lone FFh, has no effect on the count and sets no flag.
- R4: A refresh is accepted when the current count is below the start position and at or above the end position. Start codes 3, 2, 1 and 0 give 100%, 75%, 50% and 25% of the period. End codes 0, 1, 2 and 3 give 75%, 50%, 25% and 0%. A refresh at any other count is a refresh error.
- R5: When the end position is not below the start position, the end is treated as 0%.
- R6: An accepted refresh reloads the count to period − 1 and restarts the prescaler.
- R7: In NMI mode an action produces a one-cycle nmi_req and reloads the count, and counting continues. In reset mode an action raises rst_req, which stays high until rst_n, and counting halts.
- R8: With stop-after-reset set, the count holds at period − 1 and running stays low. The first refresh sequence starts counting and is never judged against the window.
- R9: With sleep hold set, a high sleep input freezes the count and the prescaler. With sleep hold clear, sleep has no effect.
- R10: stat_uflow and stat_rerr are sticky. A flag write clears each flag whose data bit (bit 0 underflow, bit 1 refresh error) is 0. A flag being set in the same cycle wins over the clear.
- R11: An underflow and a refresh error in the same cycle produce one action and set both flags. An accepted refresh in the underflow cycle wins, and no underflow happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 1 | Forces the all-ones configuration |
| cfg_word | input | 13 | Configuration word, latched after reset |
| wr_en | input | 1 | Refresh write strobe |
| wr_data | input | 8 | Refresh write byte |
| sleep | input | 1 | Low-power indication |
| flag_wr_en | input | 1 | Flag clear write strobe |
| flag_wr_data | input | 2 | A 0 in a bit clears that flag |
| count | output | 11 | Current counter value |
| running | output | 1 | Counter is active |
| stat_uflow | output | 1 | Sticky underflow flag |
| stat_rerr | output | 1 | Sticky refresh error flag |
| nmi_req | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | Held reset request |

## Verification
An underflow and the evaluation of a refresh can fall on the same clock edge. The bench provokes this by placing the FFh write on the edge where the count is zero and the prescaler ticks. With the window end at 25%, the refresh is out of window, so the bench expects one nmi_req pulse with both flags set. A flag clear written on that same edge must lose to the flag set. With the window end at 0%, the refresh is accepted, so the bench expects no pulse, no flag and a count back at period − 1.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 11;          // log2 of the longest period
  localparam int PER_W = CNT_W + 1;
  localparam int PRE_W = 8;           // log2 of the largest divider
  localparam int CFG_W = 13;

  typedef struct packed {
    logic       sleep_hold;
    logic       act_reset;
    logic [1:0] win_start;
    logic [1:0] win_end;
    logic [3:0] div_sel;
    logic [1:0] per_sel;
    logic       stop_boot;
  } wd_cfg_t;

  function automatic logic [PER_W-1:0] period_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return PER_W'(1) << 7;
      2'd1:    return PER_W'(1) << 9;
      2'd2:    return PER_W'(1) << 10;
      default: return PER_W'(1) << 11;
    endcase
  endfunction

  // divider minus one; reserved codes divide by one
  function automatic logic [PRE_W-1:0] div_limit(input logic [3:0] sel);
    case (sel)
      4'd1:    return PRE_W'(15);
      4'd2:    return PRE_W'(31);
      4'd3:    return PRE_W'(63);
      4'd4:    return PRE_W'(127);
      4'd5:    return PRE_W'(255);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pre;

  assign tick = run && (pre == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (restart) pre <= '0;
    else if (run)     pre <= (pre == limit) ? '0 : pre + 1'b1;
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CW = 11
) (
  input  logic [CW:0]   period,
  input  logic [1:0]    start_sel,
  input  logic [1:0]    end_sel,
  input  logic [CW-1:0] cnt,
  output logic          in_win
);
  logic [CW:0] qtr, half, three_q, start_pos, end_raw, end_pos, cnt_x;

  always_comb begin
    qtr     = period >> 2;
    half    = period >> 1;
    three_q = qtr + half;
    case (start_sel)
      2'd0:    start_pos = qtr;
      2'd1:    start_pos = half;
      2'd2:    start_pos = three_q;
      default: start_pos = period;
    endcase
    case (end_sel)
      2'd0:    end_raw = three_q;
      2'd1:    end_raw = half;
      2'd2:    end_raw = qtr;
      default: end_raw = '0;
    endcase
    end_pos = (end_raw >= start_pos) ? '0 : end_raw;
    cnt_x   = {1'b0, cnt};
    in_win  = (cnt_x < start_pos) && (cnt_x >= end_pos);
  end
endmodule

// File: rtl/wdog_refresh_seq.sv
module wdog_refresh_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       refresh
);
  logic armed;

  assign refresh = wr_en && armed && (wr_data == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (wr_en) armed <= (wr_data == 8'h00);
  end
endmodule

// File: rtl/wdog_windowed.sv
module wdog_windowed
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_mode,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             sleep,
  input  logic             flag_wr_en,
  input  logic [1:0]       flag_wr_data,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             stat_uflow,
  output logic             stat_rerr,
  output logic             nmi_req,
  output logic             rst_req
);
  wd_cfg_t          cfg_q, cfg_in;
  logic             cfg_vld;
  logic [PER_W-1:0] period;
  logic [PRE_W-1:0] limit;
  logic             tick, refresh, in_win;
  logic             ok_refresh, bad_refresh, start_now, uflow, action, reload;

  assign cfg_in = boot_mode ? wd_cfg_t'('1) : wd_cfg_t'(cfg_word);
  assign period = period_of(cfg_q.per_sel);
  assign limit  = div_limit(cfg_q.div_sel);

  wdog_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .run(running && !(sleep && cfg_q.sleep_hold)),
    .restart(reload), .limit(limit), .tick(tick)
  );

  wdog_window #(.CW(CNT_W)) u_win (
    .period(period), .start_sel(cfg_q.win_start), .end_sel(cfg_q.win_end),
    .cnt(count), .in_win(in_win)
  );

  wdog_refresh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .refresh(refresh)
  );

  assign ok_refresh  = refresh && running && in_win;
  assign bad_refresh = refresh && running && !in_win;
  assign start_now   = refresh && !running && cfg_vld && !rst_req;
  assign uflow       = tick && (count == '0) && !ok_refresh;
  assign action      = uflow || bad_refresh;
  assign reload      = ok_refresh || start_now || (action && !cfg_q.act_reset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= wd_cfg_t'('1);
      cfg_vld <= 1'b0;
      running <= 1'b0;
      count   <= '0;
      nmi_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      nmi_req <= action && !cfg_q.act_reset;
      if (!cfg_vld) begin
        cfg_q   <= cfg_in;
        cfg_vld <= 1'b1;
        running <= !cfg_in.stop_boot;
        count   <= CNT_W'(period_of(cfg_in.per_sel) - 1'b1);
      end else begin
        if (action && cfg_q.act_reset) begin
          rst_req <= 1'b1;
          running <= 1'b0;
        end else if (start_now) begin
          running <= 1'b1;
        end
        if (reload)                count <= CNT_W'(period - 1'b1);
        else if (tick && !action)  count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_uflow <= 1'b0;
      stat_rerr  <= 1'b0;
    end else begin
      if (uflow)                                  stat_uflow <= 1'b1;
      else if (flag_wr_en && !flag_wr_data[0])    stat_uflow <= 1'b0;
      if (bad_refresh)                            stat_rerr  <= 1'b1;
      else if (flag_wr_en && !flag_wr_data[1])    stat_rerr  <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_windowed_chk.sv
module wdog_windowed_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             sleep,
  input logic             hold,
  input logic             cfg_vld,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             stat_uflow,
  input logic             stat_rerr,
  input logic             nmi_req,
  input logic             rst_req
);
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req); // R7
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R7
  AST_ACTION_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && rst_req)); // R7
  AST_HALT_ON_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !running); // R7
  AST_NMI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (stat_uflow || stat_rerr)); // R10
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_vld && hold && sleep && !wr_en) |=> $stable(count)); // R9
  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_vld && !running && !wr_en) |=> $stable(count)); // R8
endmodule

bind wdog_windowed wdog_windowed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sleep(sleep),
  .hold(cfg_q.sleep_hold), .cfg_vld(cfg_vld), .count(count),
  .running(running), .stat_uflow(stat_uflow), .stat_rerr(stat_rerr),
  .nmi_req(nmi_req), .rst_req(rst_req)
);

// File: tb/test_wdog_windowed.sv
module test_wdog_windowed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_mode = 1'b0;
  logic [12:0] cfg_word = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        sleep = 1'b0;
  logic        flag_wr_en = 1'b0;
  logic [1:0]  flag_wr_data = '0;
  logic [10:0] count;
  logic        running, stat_uflow, stat_rerr, nmi_req, rst_req;
  int          total = 0;
  int          fails = 0;
  int          cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  wdog_windowed i_wdog_windowed (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cfg_word(cfg_word),
    .wr_en(wr_en), .wr_data(wr_data), .sleep(sleep),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .count(count), .running(running), .stat_uflow(stat_uflow),
    .stat_rerr(stat_rerr), .nmi_req(nmi_req), .rst_req(rst_req)
  );

  // {config word, expected cycles to underflow}: NMI mode, full window
  localparam logic [12:0] VCFG [10] = '{13'h780, 13'h782, 13'h784, 13'h786, 13'h788,
                                        13'h790, 13'h798, 13'h7A0, 13'h7A8, 13'h7C8};
  localparam int VEXP [10] = '{128, 512, 1024, 2048, 2048, 4096, 8192, 16384, 32768, 128};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [12:0] cfg, input logic boot);
    @(negedge clk);
    rst_n = 1'b0; cfg_word = cfg; boot_mode = boot;
    wr_en = 1'b0; sleep = 1'b0; flag_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);   // configuration edge passed: reference point
  endtask

  // FFh write lands on edge k after the reference point
  task automatic refresh_at(input int k);
    repeat (k - 2) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input bit use_rst, input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if ((use_rst ? rst_req : nmi_req) === 1'b1) begin n = i; break; end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        total++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    int n;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(!nmi_req && !rst_req && !running && !stat_uflow && !stat_rerr, "R1 reset outputs",
        {nmi_req, rst_req, running, stat_uflow, stat_rerr}, 0);

    // R2 vector walk
    for (int v = 0; v < 10; v++) begin
      do_reset(VCFG[v], 1'b0);
      measure(1'b0, 40000, n);
      chk(n == VEXP[v], "R2 timeout length", n, VEXP[v]);
    end
    @(negedge clk);
    chk(nmi_req == 1'b0, "R7 nmi single pulse", nmi_req, 0);

    // R1 boot mode forces all ones: stopped, period 2048
    do_reset(13'h780, 1'b1);
    repeat (50) @(negedge clk);
    chk(!running && count == 11'd2047, "R1 boot mode all ones", count, 2047);

    // R8 stopped after reset, first refresh starts
    do_reset(13'h781, 1'b0);
    repeat (200) @(negedge clk);
    chk(!running && count == 11'd127 && !nmi_req, "R8 stays stopped", count, 127);
    refresh_at(5);
    chk(running == 1'b1, "R8 refresh starts", running, 1);
    measure(1'b0, 1000, n);
    chk(n == 128, "R8 R6 timeout after start", n, 128);

    // R4 window 75%..25%
    do_reset(13'h500, 1'b0);
    refresh_at(32);
    chk(nmi_req && stat_rerr && !stat_uflow, "R4 early refresh error",
        {nmi_req, stat_rerr, stat_uflow}, 3'b110);
    chk(count == 11'd127, "R7 nmi mode reloads", count, 127);
    flag_wr_en = 1'b1; flag_wr_data = 2'b00;
    @(negedge clk);
    flag_wr_en = 1'b0;
    chk(!stat_rerr && !stat_uflow, "R10 write zero clears", stat_rerr, 0);
    do_reset(13'h500, 1'b0);
    refresh_at(33);
    chk(!nmi_req && !stat_rerr && count == 11'd127, "R4 R6 accepted at start edge", count, 127);
    refresh_at(96);
    chk(!nmi_req && !stat_rerr && count == 11'd127, "R4 accepted at end edge", count, 127);
    refresh_at(97);
    chk(nmi_req && stat_rerr, "R4 late refresh error", stat_rerr, 1);

    // R5 end not below start -> end 0%; R11 accepted refresh beats underflow
    do_reset(13'h280, 1'b0);
    refresh_at(120);
    chk(!nmi_req && !stat_rerr && count == 11'd127, "R5 end forced to zero", count, 127);
    refresh_at(128);
    chk(!nmi_req && !stat_uflow && !stat_rerr && count == 11'd127,
        "R11 refresh wins over underflow", count, 127);
    refresh_at(64);
    chk(nmi_req && stat_rerr, "R5 start still applies", stat_rerr, 1);

    // R11 underflow and refresh error together, R10 set beats clear
    do_reset(13'h500, 1'b0);
    repeat (126) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_data = 8'hFF; flag_wr_en = 1'b1; flag_wr_data = 2'b00;
    @(negedge clk);
    wr_en = 1'b0; flag_wr_en = 1'b0;
    chk(nmi_req && stat_uflow && stat_rerr, "R11 both flags one action",
        {nmi_req, stat_uflow, stat_rerr}, 3'b111);
    @(negedge clk);
    chk(!nmi_req, "R11 R7 single pulse", nmi_req, 0);
    flag_wr_en = 1'b1; flag_wr_data = 2'b01;
    @(negedge clk);
    flag_wr_en = 1'b0;
    chk(stat_uflow && !stat_rerr, "R10 per-bit clear", {stat_uflow, stat_rerr}, 2'b10);

    // R3 write order
    do_reset(13'h780, 1'b0);
    wr_byte(8'h00); wr_byte(8'h55); wr_byte(8'hFF);
    chk(count == 11'd124 && !stat_rerr, "R3 broken order ignored", count, 124);
    wr_byte(8'hFF);
    chk(count == 11'd123 && !stat_rerr && !nmi_req, "R3 lone FF ignored", count, 123);
    wr_byte(8'h00); wr_byte(8'h00); wr_byte(8'hFF);
    chk(count == 11'd127, "R3 R6 valid sequence reloads", count, 127);

    // R9 sleep hold
    do_reset(13'h1780, 1'b0);
    repeat (10) @(negedge clk);
    chk(count == 11'd117, "R9 counting before sleep", count, 117);
    sleep = 1'b1;
    repeat (20) @(negedge clk);
    chk(count == 11'd117, "R9 frozen in sleep", count, 117);
    sleep = 1'b0;
    repeat (5) @(negedge clk);
    chk(count == 11'd112, "R9 resumes", count, 112);
    do_reset(13'h780, 1'b0);
    repeat (10) @(negedge clk);
    sleep = 1'b1;
    repeat (10) @(negedge clk);
    sleep = 1'b0;
    chk(count == 11'd107, "R9 no hold keeps counting", count, 107);

    // R7 reset mode
    do_reset(13'hF80, 1'b0);
    measure(1'b1, 1000, n);
    chk(n == 128, "R7 reset request timing", n, 128);
    chk(!nmi_req && !running && stat_uflow, "R7 halted no nmi",
        {nmi_req, running, stat_uflow}, 3'b001);
    refresh_at(50);
    chk(rst_req && !running, "R7 request held, no restart", {rst_req, running}, 2'b10);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!rst_req, "R7 cleared by reset", rst_req, 0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule